// File: doc/BRIEF.md
# Delay-per-element calibration calculator

This block turns raw calibration counts for a programmable I/O delay line into two delay-per-element figures, one for the coarse line and one for the fine line. Its inputs are a 16-bit reference clock period and, for each line, a 16-bit reference count and a 16-bit delay count. Software or a boot sequencer later divides requested delays by these figures to choose how many elements to enable.

When a start pulse is accepted, the block latches its inputs. It then runs one restoring division for the coarse line and, if that step succeeds, one for the fine line. Each division yields one quotient bit per clock. At the end it pulses `done` and raises `err` if either step failed. The two 32-bit results and the error flag then hold until the next accepted start.

Each figure is the scaled ratio (10 × period × reference count) / (2 × delay count × multiplier). The multiplier is fixed for each line. A zero delay count, or a quotient that truncates to zero, stops the sequence with an error.

Top module: `dpe_calc`

## Requirements
- R1: Each result is floor((10 × period × ref) / (2 × dly × mult)). Both products are formed at 64 bits, and the result port carries the low 32 bits of the quotient.
- R2: The coarse result uses multiplier 88 and the fine result uses multiplier 264.
- R3: A coarse delay count of zero ends the sequence with `err`=1. `done` rises at the 1st clock edge after the edge that accepts start, and both results read 0.
- R4: A coarse quotient of zero ends the sequence with `err`=1 at edge 66 after the accepting edge. The fine step is skipped, so the fine result reads 0.
- R5: A fine delay count of zero ends the sequence with `err`=1 at edge 67 after the accepting edge. The coarse result keeps its computed value.
- R6: A fine quotient of zero ends the sequence with `err`=1 at edge 132 after the accepting edge.
- R7: A successful sequence raises `done` with `err`=0 at edge 132 after the accepting edge, and both results are nonzero.
- R8: `busy` is 1 from the edge that accepts start until the edge that raises `done`. `done` lasts one cycle per sequence and is never high together with `busy`.
- R9: A start pulse that arrives while `busy`=1 is ignored. The running sequence completes with the operands latched at its own start.
- R10: An accepted start clears both results and `err`. While idle, the results and `err` hold their values, whatever the inputs do.
- R11: After reset, `busy`, `done`, `err` and both results are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| period | input | 16 | Reference clock period count |
| crs_ref | input | 16 | Coarse line reference count |
| crs_dly | input | 16 | Coarse line delay count |
| fin_ref | input | 16 | Fine line reference count |
| fin_dly | input | 16 | Fine line delay count |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence failed (held) |
| crs_dpe | output | 32 | Coarse delay-per-element result (held) |
| fin_dpe | output | 32 | Fine delay-per-element result (held) |

## Verification
The hardest cases to reach are the error exits in the middle of a sequence. These are a coarse quotient that truncates to zero, which skips the fine step, and a fine step that fails after a valid coarse result was stored. The stimulus reaches them with tiny periods and reference counts, so that the scaled numerator falls below 176 or 528, while the other line keeps valid operands. A start pulse is also injected partway through a busy sequence with different operands, and the bench model checks that the result still matches the original operands.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

    localparam int CNT_W       = 16;
    localparam int DIV_W       = 64;
    localparam int RES_W       = 32;
    localparam int NUM_SCALE   = 10;
    localparam int DEN_SCALE   = 2;
    localparam int COARSE_MULT = 88;
    localparam int FINE_MULT   = 264;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PREP,
        PH_WAIT
    } phase_t;

    typedef enum logic {
        LN_COARSE,
        LN_FINE
    } line_t;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] crs_ref;
        logic [CNT_W-1:0] crs_dly;
        logic [CNT_W-1:0] fin_ref;
        logic [CNT_W-1:0] fin_dly;
    } cal_cfg_t;

    function automatic logic [DIV_W-1:0] scaled_num(
        input logic [CNT_W-1:0] per,
        input logic [CNT_W-1:0] refc
    );
        return DIV_W'(NUM_SCALE) * DIV_W'(per) * DIV_W'(refc);
    endfunction

    function automatic logic [DIV_W-1:0] scaled_den(
        input logic [CNT_W-1:0] dly,
        input int unsigned      mult
    );
        return DIV_W'(DEN_SCALE) * DIV_W'(dly) * DIV_W'(mult);
    endfunction

endpackage

// File: rtl/dpe_operand.sv
module dpe_operand
    import dpe_pkg::*;
#(
    parameter int unsigned COARSE_MULT_P = COARSE_MULT,
    parameter int unsigned FINE_MULT_P   = FINE_MULT
) (
    input  line_t            sel,
    input  cal_cfg_t         cfg,
    output logic [DIV_W-1:0] num,
    output logic [DIV_W-1:0] den,
    output logic             dly_zero
);
    logic [CNT_W-1:0] ref_sel;
    logic [CNT_W-1:0] dly_sel;
    int unsigned      mult_sel;

    always_comb begin
        if (sel == LN_COARSE) begin
            ref_sel  = cfg.crs_ref;
            dly_sel  = cfg.crs_dly;
            mult_sel = COARSE_MULT_P;
        end else begin
            ref_sel  = cfg.fin_ref;
            dly_sel  = cfg.fin_dly;
            mult_sel = FINE_MULT_P;
        end
        num      = scaled_num(cfg.period, ref_sel);
        den      = scaled_den(dly_sel, mult_sel);
        dly_zero = (dly_sel == '0);
    end
endmodule

// File: rtl/dpe_divider.sv
module dpe_divider #(
    parameter int W     = 64,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [W-1:0]     num,
    input  logic [W-1:0]     den,
    output logic [OUT_W-1:0] quo,
    output logic             fin
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                rem_q <= '0;
                quo_q <= num;
                den_q <= den;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(W - 1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q[OUT_W-1:0];
endmodule

// File: rtl/dpe_calc.sv
module dpe_calc
    import dpe_pkg::*;
#(
    parameter int unsigned COARSE_MULT_P = COARSE_MULT,
    parameter int unsigned FINE_MULT_P   = FINE_MULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] crs_ref,
    input  logic [CNT_W-1:0] crs_dly,
    input  logic [CNT_W-1:0] fin_ref,
    input  logic [CNT_W-1:0] fin_dly,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [RES_W-1:0] crs_dpe,
    output logic [RES_W-1:0] fin_dpe
);
    phase_t           phase_q;
    line_t            line_q;
    cal_cfg_t         cfg_q;
    logic [DIV_W-1:0] op_num;
    logic [DIV_W-1:0] op_den;
    logic             op_dly_zero;
    logic             div_load;
    logic             div_fin;
    logic [RES_W-1:0] div_quo;

    dpe_operand #(
        .COARSE_MULT_P(COARSE_MULT_P),
        .FINE_MULT_P  (FINE_MULT_P)
    ) u_operand (
        .sel     (line_q),
        .cfg     (cfg_q),
        .num     (op_num),
        .den     (op_den),
        .dly_zero(op_dly_zero)
    );

    assign div_load = (phase_q == PH_PREP) && !op_dly_zero;

    dpe_divider #(
        .W    (DIV_W),
        .OUT_W(RES_W)
    ) u_divider (
        .clk (clk),
        .rst (rst),
        .load(div_load),
        .num (op_num),
        .den (op_den),
        .quo (div_quo),
        .fin (div_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            line_q  <= LN_COARSE;
            cfg_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            crs_dpe <= '0;
            fin_dpe <= '0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        cfg_q   <= '{period: period, crs_ref: crs_ref, crs_dly: crs_dly,
                                     fin_ref: fin_ref, fin_dly: fin_dly};
                        line_q  <= LN_COARSE;
                        err     <= 1'b0;
                        crs_dpe <= '0;
                        fin_dpe <= '0;
                        phase_q <= PH_PREP;
                    end
                end
                PH_PREP: begin
                    if (op_dly_zero) begin
                        done    <= 1'b1;
                        err     <= 1'b1;
                        phase_q <= PH_IDLE;
                    end else begin
                        phase_q <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (div_fin) begin
                        if (div_quo == '0) begin
                            done    <= 1'b1;
                            err     <= 1'b1;
                            phase_q <= PH_IDLE;
                        end else if (line_q == LN_COARSE) begin
                            crs_dpe <= div_quo;
                            line_q  <= LN_FINE;
                            phase_q <= PH_PREP;
                        end else begin
                            fin_dpe <= div_quo;
                            done    <= 1'b1;
                            phase_q <= PH_IDLE;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q != PH_IDLE);
endmodule

// File: rtl/dpe_calc_chk.sv
module dpe_calc_chk
    import dpe_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [RES_W-1:0] crs_dpe,
    input logic [RES_W-1:0] fin_dpe
);
    logic [15:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)                lat_cnt <= '0;
        else if (start && !busy) lat_cnt <= '0;
        else if (busy)           lat_cnt <= lat_cnt + 1'b1;
    end

    // R8
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    a_r8_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
    a_r8_accept_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R10
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(crs_dpe) && $stable(fin_dpe) && $stable(err)));
    // R7
    a_r7_success_nonzero: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (crs_dpe != '0 && fin_dpe != '0));
    a_r7_success_latency: assert property (@(posedge clk) disable iff (rst)
        (done && !err) |-> (lat_cnt == 16'(2 * DIV_W + 4)));
    // R3 R4 R5 R6
    a_r6_error_latency: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (lat_cnt == 16'd1 || lat_cnt == 16'(DIV_W + 2) ||
                           lat_cnt == 16'(DIV_W + 3) || lat_cnt == 16'(2 * DIV_W + 4)));
    // R4
    a_r4_fine_skipped: assert property (@(posedge clk) disable iff (rst)
        (done && crs_dpe == '0) |-> (err && fin_dpe == '0));
endmodule

bind dpe_calc dpe_calc_chk u_dpe_calc_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .crs_dpe(crs_dpe),
    .fin_dpe(fin_dpe)
);

// File: tb/test_dpe_calc.sv
module test_dpe_calc;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] period = '0, crs_ref = '0, crs_dly = '0, fin_ref = '0, fin_dly = '0;
    logic        busy, done, err;
    logic [31:0] crs_dpe, fin_dpe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit chk_en = 1'b0;
    string tag = "R11";

    // behavioural model state
    bit          m_busy = 0, m_done = 0, m_err = 0;
    int          m_cnt = 0;
    logic [31:0] m_crs = '0, m_fin = '0;
    bit          f_err = 0;
    logic [31:0] f_crs = '0, f_fin = '0;

    always #5 clk = ~clk;

    dpe_calc i_dpe_calc (
        .clk(clk), .rst(rst), .start(start),
        .period(period), .crs_ref(crs_ref), .crs_dly(crs_dly),
        .fin_ref(fin_ref), .fin_dly(fin_dly),
        .busy(busy), .done(done), .err(err),
        .crs_dpe(crs_dpe), .fin_dpe(fin_dpe)
    );

    function automatic longint unsigned ratio(input longint unsigned p, input longint unsigned r,
                                              input longint unsigned d, input longint unsigned m);
        return (p * r * 64'd10) / (d * m * 64'd2);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_err = 0; m_crs = '0; m_fin = '0; m_cnt = 0;
        end else if (m_busy) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin
                m_busy = 0; m_done = 1; m_err = f_err; m_crs = f_crs; m_fin = f_fin;
            end
        end else begin
            m_done = 0;
            if (start) begin
                longint unsigned qc, qf;
                m_busy = 1; m_err = 0; m_crs = '0; m_fin = '0;
                f_crs = '0; f_fin = '0; f_err = 1;
                if (crs_dly == 0) m_cnt = 1;
                else begin
                    qc = ratio(period, crs_ref, crs_dly, 88);
                    if (qc[31:0] == 0) m_cnt = 66;
                    else begin
                        f_crs = qc[31:0];
                        if (fin_dly == 0) m_cnt = 67;
                        else begin
                            qf = ratio(period, fin_ref, fin_dly, 264);
                            m_cnt = 132;
                            if (qf[31:0] != 0) begin
                                f_fin = qf[31:0]; f_err = 0;
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (chk_en) begin
            chk("R8", "busy", busy, m_busy);
            chk("R8", "done", done, m_done);
            chk(tag, "err", err, m_err);
            if (!m_busy) begin
                chk(tag, "crs_dpe", crs_dpe, m_crs);
                chk(tag, "fin_dpe", fin_dpe, m_fin);
            end
        end
        if (cycles > 50000) begin
            failures++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run(input string t, input logic [15:0] p, cr, cd, fr, fd, input int wait_cyc);
        @(negedge clk);
        tag = t;
        period = p; crs_ref = cr; crs_dly = cd; fin_ref = fr; fin_dly = fd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (wait_cyc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_en = 1'b1;
        @(negedge clk);
        // R11 reset state (also compared by the model loop)
        chk("R11", "reset busy", busy, 0);
        chk("R11", "reset results", crs_dpe | fin_dpe, 0);

        run("R1", 16'd10000, 16'd1000, 16'd5000, 16'd1000, 16'd5000, 140);
        chk("R2", "coarse mult 88", crs_dpe, 113);
        chk("R2", "fine mult 264", fin_dpe, 37);
        run("R7", 16'hFFFF, 16'hFFFF, 16'd1, 16'hFFFF, 16'd1, 140);
        run("R1", 16'd3333, 16'd777, 16'd19, 16'd4242, 16'd65535, 140);
        run("R3", 16'd500, 16'd100, 16'd0, 16'd100, 16'd7, 10);
        run("R4", 16'd1, 16'd1, 16'd1, 16'd900, 16'd1, 80);
        run("R5", 16'd2000, 16'd300, 16'd40, 16'd300, 16'd0, 80);
        run("R6", 16'd1, 16'd100, 16'd1, 16'd1, 16'd1, 140);
        // R9: second start during busy with other operands
        run("R9", 16'd8000, 16'd512, 16'd64, 16'd2048, 16'd96, 20);
        tag = "R9";
        period = 16'd1; crs_dly = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (120) @(negedge clk);
        // R10: inputs wander while idle
        tag = "R10";
        for (int k = 0; k < 20; k++) begin
            period = 16'(k * 37); crs_dly = 16'(k); fin_ref = 16'(k * 5);
            @(negedge clk);
        end
        chk("R10", "held coarse nonzero", (crs_dpe != 0), 1);
        // back-to-back: start in the done cycle
        run("R3", 16'd9, 16'd9, 16'd0, 16'd9, 16'd9, 0);
        run("R7", 16'd40000, 16'd60000, 16'd3, 16'd60000, 16'd9, 140);
        repeat (5) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule